// File: doc/BRIEF.md
# Moore 110 Sequence Detector

This block watches a single-bit serial input that is sampled on every rising clock edge. It raises its output for one clock cycle once the three most recent samples were 1, then 1, then 0. It is a Moore machine, so the output is decoded from the stored state alone and the current input level never reaches it through logic.

The machine holds two state flip-flops. The low bit holds the previous input sample, so its next-state logic is a plain wire from the input. The high bit is set on a run of ones and is kept for one extra edge so that a closing zero can be recognised. The state is also brought out on a port so that it can be checked.

An active-low reset forces the all-zeros state, which is also the state for "no 1 seen yet". A parameter chooses whether the reset acts asynchronously or on the next clock edge.

Top module: `seq110_detector`

## Requirements
- R1: While `rst_n` is low, the state is cleared to `state_q` = 2'b00 and `detect` is 0. In the asynchronous variant this happens at once. In the synchronous variant it happens at the next rising edge.
- R2: After each rising edge with reset released, `state_q[0]` equals the `din` value sampled at that edge.
- R3: `detect` is 1 in a cycle exactly when the last three sampled `din` values were 1, 1, 0, oldest first. Otherwise it is 0.
- R4: `detect` depends only on the state. Changing `din` between clock edges leaves `detect` unchanged until the next edge.
- R5: `state_q` is {high bit, low bit} and uses these codes: 2'b00 means no 1 seen, 2'b01 means a single 1, 2'b11 means two or more consecutive 1s, and 2'b10 means 110 found.
- R6: From the found state (2'b10), a sampled 1 moves the machine to 2'b01 and a sampled 0 moves it to 2'b00.
- R7: While `din` is held at 1, the machine stays in 2'b11 and `detect` stays 0.
- R8: Patterns that share bits are recognised each time they complete. The pattern 1,1,0,1,1,0 produces two `detect` pulses, and the pattern 1,0,1 produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset to state 2'b00 |
| din | input | 1 | Serial input sampled on each rising edge |
| detect | output | 1 | High for one cycle after 1,1,0 is seen |
| state_q | output | 2 | Current state bits {high, low} |

## Verification
The bench builds two copies of the block side by side: one with `ASYNC_RESET` = 1 and one with `ASYNC_RESET` = 0. Both copies get the same stimulus and must produce the same expected values. With both variants present, a reset asserted between clock edges shows its different timing: the asynchronous copy clears at once, while the synchronous copy still shows its old state until the next edge. Toggling the input between edges in every state shows whether the input leaks into the output.

// File: rtl/seq110_pkg.sv
package seq110_pkg;
   localparam int STATE_W = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_NONE  = 2'b00,
      ST_ONE   = 2'b01,
      ST_RUN   = 2'b11,
      ST_FOUND = 2'b10
   } seq_state_e;
endpackage

// File: rtl/seq110_next.sv
module seq110_next
   import seq110_pkg::*;
(
   input  logic [STATE_W-1:0] cur_q,
   input  logic               din,
   output logic [STATE_W-1:0] nxt_d
);
   // Low bit stores the last sample; high bit marks a run of ones,
   // kept one more edge so a closing zero can be recognised.
   always_comb begin
      nxt_d[0] = din;
      nxt_d[1] = (cur_q[0] & din) | (cur_q[1] & cur_q[0]);
   end
endmodule

// File: rtl/seq110_state_reg.sv
module seq110_state_reg
   import seq110_pkg::*;
#(
   parameter int ASYNC_RESET = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STATE_W-1:0] nxt_d,
   output logic [STATE_W-1:0] cur_q
);
   localparam logic [STATE_W-1:0] RESET_CODE = ST_NONE;

   generate
      if (ASYNC_RESET == 1) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur_q <= RESET_CODE;
            else        cur_q <= nxt_d;
         end
      end else if (ASYNC_RESET == 0) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) cur_q <= RESET_CODE;
            else        cur_q <= nxt_d;
         end
      end else begin : g_bad
         $error("seq110_state_reg: ASYNC_RESET must be 0 or 1");
         assign cur_q = RESET_CODE;
      end
   endgenerate
endmodule

// File: rtl/seq110_out_dec.sv
module seq110_out_dec
   import seq110_pkg::*;
(
   input  logic [STATE_W-1:0] cur_q,
   output logic               detect
);
   // Found is the only code with the high bit set and the low bit clear.
   assign detect = cur_q[1] & ~cur_q[0];
endmodule

// File: rtl/seq110_detector.sv
module seq110_detector
   import seq110_pkg::*;
#(
   parameter int ASYNC_RESET = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               din,
   output logic               detect,
   output logic [1:0]         state_q
);
   generate
      if (STATE_W != 2) begin : g_width_chk
         $error("seq110_detector: state width must be 2");
      end
   endgenerate

   logic [STATE_W-1:0] nxt_d;
   logic [STATE_W-1:0] cur_q;

   seq110_next u_next (
      .cur_q (cur_q),
      .din   (din),
      .nxt_d (nxt_d)
   );

   seq110_state_reg #(.ASYNC_RESET(ASYNC_RESET)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt_d (nxt_d),
      .cur_q (cur_q)
   );

   seq110_out_dec u_dec (
      .cur_q  (cur_q),
      .detect (detect)
   );

   assign state_q = cur_q;
endmodule

// File: rtl/seq110_detector_chk.sv
module seq110_detector_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       din,
   input logic       detect,
   input logic [1:0] state_q
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (state_q == 2'b00 && !detect)); // R1

   AST_LOW_BIT_PREV_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> state_q[0] == $past(din)); // R2

   AST_DETECT_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n,2) && $past(rst_n,3) && detect)
      |-> (!$past(din) && $past(din,2) && $past(din,3))); // R3

   AST_DETECT_ONLY_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
      detect |-> (state_q == 2'b10)); // R5

   AST_FOUND_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == 2'b10) |=> (state_q == ($past(din) ? 2'b01 : 2'b00))); // R6

   AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == 2'b11 && din) |=> (state_q == 2'b11 && !detect)); // R7
endmodule

bind seq110_detector seq110_detector_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .din     (din),
   .detect  (detect),
   .state_q (state_q)
);

// File: tb/tb_seq110_detector.sv
`timescale 1ns/1ps
module tb_seq110_detector;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       din = 1'b0;
   logic       det_a, det_s;
   logic [1:0] st_a, st_s;
   int         checks = 0;
   int         errors = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   seq110_detector #(.ASYNC_RESET(1)) dut (
      .clk(clk), .rst_n(rst_n), .din(din), .detect(det_a), .state_q(st_a));
   seq110_detector #(.ASYNC_RESET(0)) dut_sync (
      .clk(clk), .rst_n(rst_n), .din(din), .detect(det_s), .state_q(st_s));

   // {din, expected state after edge, expected detect}
   localparam logic [3:0] VEC [0:15] = '{
      4'b1_01_0, 4'b1_11_0, 4'b0_10_1, 4'b1_01_0,
      4'b1_11_0, 4'b1_11_0, 4'b1_11_0, 4'b0_10_1,
      4'b0_00_0, 4'b0_00_0, 4'b1_01_0, 4'b0_00_0,
      4'b1_01_0, 4'b1_11_0, 4'b0_10_1, 4'b0_00_0
   };

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual {state,detect}=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic step(input logic v);
      @(negedge clk) din = v;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 async reset", {st_a, det_a}, 3'b000);
      chk("R1 sync reset",  {st_s, det_s}, 3'b000);
      @(negedge clk) rst_n = 1'b1;

      // R2 R3 R5 R6 R7 R8: vector walk
      for (int i = 0; i < 16; i++) begin
         step(VEC[i][3]);
         chk($sformatf("R2/R3/R5/R6/R7/R8 vec%0d async", i), {st_a, det_a}, VEC[i][2:0]);
         chk($sformatf("R2/R3/R5/R6/R7/R8 vec%0d sync", i),  {st_s, det_s}, VEC[i][2:0]);
      end

      // R4: toggle din between edges while in found state
      step(1); step(1); step(0);
      chk("R4 found entry", {st_a, det_a}, 3'b101);
      for (int k = 0; k < 4; k++) begin
         #0.5 din = ~din;
         chk("R4 detect stable async", {st_a, det_a}, 3'b101);
         chk("R4 detect stable sync",  {st_s, det_s}, 3'b101);
      end

      // R7: long run of ones
      for (int k = 0; k < 6; k++) step(1);
      chk("R7 held ones async", {st_a, det_a}, 3'b110);
      chk("R7 held ones sync",  {st_s, det_s}, 3'b110);

      // R1: reset between edges; async clears at once, sync at the edge
      @(negedge clk) rst_n = 1'b0;
      #0.5;
      chk("R1 async immediate", {st_a, det_a}, 3'b000);
      chk("R1 sync waits edge", {st_s, det_s}, 3'b110);
      @(posedge clk); #1;
      chk("R1 sync after edge", {st_s, det_s}, 3'b000);
      @(negedge clk) rst_n = 1'b1;

      // R3: after reset the old run of ones is gone, so a zero does not detect
      step(0);
      chk("R3 no detect after reset", {st_a, det_a}, 3'b000);
      chk("R3 no detect after reset sync", {st_s, det_s}, 3'b000);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule